// File: doc/BRIEF.md
# CSR Access Unit with Claimed Device Bus

This block is the register-access path used by the system-register instructions of a small processor core. A 12-bit register address and a control-and-status access strobe arrive from the decoder. Every register device on an internal bus compares that address against its own. The device that matches raises a claim and returns its value. All other devices drive zero. The bus read value and the bus claim are each the bitwise OR of the per-device outputs.

The value to be written is picked by a 2-bit source select. The choices are the first source register, the result from the arithmetic unit, and the 5-bit instruction immediate zero-extended. The arithmetic unit forms set and clear results from the returned read value. When no device claims an access, the unit reports an illegal instruction so that the core can trap. A write aimed at a read-only register is also reported as illegal.

Two example devices are attached. One is a read/write scratch register at 0x340. The other is a read-only free-running cycle counter at 0xC00.

Top module: `csr_access_unit`

## Requirements
- R1: The register address is the 12-bit `csr_addr` input. A device claims only when `access_en` is 1 and `csr_addr` equals its own address (scratch 0x340, counter 0xC00).
- R2: `rd_value` carries the claimed device's current value. When nothing claims, `rd_value` is zero.
- R3: At most one device claims at any time, and `claim` is 1 exactly when some device claims.
- R4: `illegal` is 1 when `access_en` is 1 and no device claims. It is 0 when `access_en` is 0.
- R5: Source select 0 (binary 00) writes `rs1_val`.
- R6: Source select 1 (binary 01) writes `alu_val`.
- R7: Source select 2 (binary 10) writes `uimm` zero-extended to 32 bits.
- R8: Source select 3 (binary 11) writes zero.
- R9: A write happens on the rising clock edge only when `access_en` and `wr_en` are both 1 and the scratch register claims. Writes while `access_en` is 0, or to an unclaimed address, leave the scratch register unchanged.
- R10: The counter reads 0 during reset and increases by exactly 1 on every rising clock edge after reset.
- R11: A write to the counter is claimed and flagged `illegal`, and the counter keeps counting without taking the written value.
- R12: After reset, the scratch register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| access_en | input | 1 | A system-register instruction is executing |
| wr_en | input | 1 | The instruction requests a register write |
| csr_addr | input | 12 | Register address from the instruction |
| wsrc_sel | input | 2 | Write-value source: 0 rs1, 1 alu, 2 uimm, 3 zero |
| rs1_val | input | 32 | First source register value |
| alu_val | input | 32 | Arithmetic-unit result (set/clear forms) |
| uimm | input | 5 | Immediate field of the instruction |
| rd_value | output | 32 | OR-combined read value for rd and for set/clear |
| claim | output | 1 | OR-combined device claim |
| illegal | output | 1 | Unclaimed access, or write to a read-only register |

## Verification
The devices hold the only state, so a wrong stored value in either one shows on `rd_value` at the next read of that address. A write taken from the wrong source shows at the read that follows the write edge, which is one cycle later. A counter that skips a step, stalls, or takes a written value shows as a difference between two reads that does not match the number of elapsed edges. A device that claims a foreign address shows at once as a nonzero `rd_value` or a raised `claim` on an address that should read zero and trap.

// File: rtl/csr_bus_pkg.sv
package csr_bus_pkg;

    localparam int CSR_AW = 12;
    localparam int CSR_DW = 32;

    typedef enum logic [1:0] {
        WSRC_RS1  = 2'd0,
        WSRC_ALU  = 2'd1,
        WSRC_UIMM = 2'd2,
        WSRC_ZERO = 2'd3
    } wsrc_e;

endpackage

// File: rtl/csr_wsrc_mux.sv
module csr_wsrc_mux
    import csr_bus_pkg::*;
#(
    parameter int DW = CSR_DW,
    parameter int UW = 5
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] rs1_val,
    input  logic [DW-1:0] alu_val,
    input  logic [UW-1:0] uimm,
    output logic [DW-1:0] wdata
);

    localparam int PAD_W = DW - UW;

    always_comb begin
        unique case (wsrc_e'(sel))
            WSRC_RS1:  wdata = rs1_val;
            WSRC_ALU:  wdata = alu_val;
            WSRC_UIMM: wdata = {{PAD_W{1'b0}}, uimm};
            default:   wdata = '0;
        endcase
    end

endmodule

// File: rtl/csr_reg_dev.sv
module csr_reg_dev #(
    parameter int              AW        = 12,
    parameter int              DW        = 32,
    parameter logic [AW-1:0]   DEV_ADDR  = '0,
    parameter bit              READ_ONLY = 1'b0,
    parameter bit              AUTO_INC  = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          claim_o,
    output logic [DW-1:0] rdata_o,
    output logic          ro_write_o
);

    typedef struct packed {
        logic [DW-1:0] value;
    } dev_state_t;

    dev_state_t st_d, st_q;
    logic       hit;
    logic       do_write;

    assign hit        = access_en && (addr == DEV_ADDR);
    assign do_write   = hit && wr_en && !READ_ONLY;
    assign claim_o    = hit;
    assign rdata_o    = hit ? st_q.value : '0;
    assign ro_write_o = hit && wr_en && READ_ONLY;

    always_comb begin
        st_d = st_q;
        if (AUTO_INC) begin
            st_d.value = st_q.value + 1'b1;
        end
        if (do_write) begin
            st_d.value = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        if (!READ_ONLY) begin : g_rw_chk
            // R9: a claimed write lands on the next edge
            p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && wr_en) |=> (st_q.value == $past(wdata)));
            // R9: without a claimed write, a plain register keeps its value
            if (!AUTO_INC) begin : g_hold_chk
                p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    !(hit && wr_en) |=> $stable(st_q.value));
            end
        end else begin : g_ro_chk
            // R11: a write attempt never replaces the stored value
            if (AUTO_INC) begin : g_cnt_chk
                p_count_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> (st_q.value == $past(st_q.value) + 1'b1));
            end else begin : g_const_chk
                p_ro_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
                    1'b1 |=> $stable(st_q.value));
            end
        end
    endgenerate

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_bus_pkg::*;
#(
    parameter int            AW           = CSR_AW,
    parameter int            DW           = CSR_DW,
    parameter int            UW           = 5,
    parameter logic [AW-1:0] SCRATCH_ADDR = 12'h340,
    parameter logic [AW-1:0] COUNTER_ADDR = 12'hC00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          access_en,
    input  logic          wr_en,
    input  logic [AW-1:0] csr_addr,
    input  logic [1:0]    wsrc_sel,
    input  logic [DW-1:0] rs1_val,
    input  logic [DW-1:0] alu_val,
    input  logic [UW-1:0] uimm,
    output logic [DW-1:0] rd_value,
    output logic          claim,
    output logic          illegal
);

    localparam int NDEV = 2;
    localparam logic [NDEV*AW-1:0] DEV_ADDRS = {COUNTER_ADDR, SCRATCH_ADDR};
    localparam logic [NDEV-1:0]    DEV_RO    = 2'b10;
    localparam logic [NDEV-1:0]    DEV_INC   = 2'b10;

    logic [DW-1:0] wdata;
    logic [DW-1:0] dev_rdata [NDEV];
    logic [NDEV-1:0] dev_claim;
    logic [NDEV-1:0] dev_ro_write;
    logic            ro_write_any;

    csr_wsrc_mux #(.DW(DW), .UW(UW)) wsrc_mux_i (
        .sel     (wsrc_sel),
        .rs1_val (rs1_val),
        .alu_val (alu_val),
        .uimm    (uimm),
        .wdata   (wdata)
    );

    generate
        for (genvar g = 0; g < NDEV; g++) begin : g_dev
            csr_reg_dev #(
                .AW        (AW),
                .DW        (DW),
                .DEV_ADDR  (DEV_ADDRS[g*AW +: AW]),
                .READ_ONLY (DEV_RO[g]),
                .AUTO_INC  (DEV_INC[g])
            ) dev_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .access_en  (access_en),
                .wr_en      (wr_en),
                .addr       (csr_addr),
                .wdata      (wdata),
                .claim_o    (dev_claim[g]),
                .rdata_o    (dev_rdata[g]),
                .ro_write_o (dev_ro_write[g])
            );
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NDEV; i++) begin
            rd_value = rd_value | dev_rdata[i];
        end
    end

    assign claim        = |dev_claim;
    assign ro_write_any = |dev_ro_write;
    assign illegal      = access_en && (!claim || ro_write_any);

    // R3: devices never claim together
    p_single_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_claim));
    // R2: an unclaimed bus returns zero
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !claim |-> (rd_value == '0));
    // R4: no claim during an access means a trap
    p_unclaimed_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (access_en && !claim) |-> illegal);
    // R4: no trap outside an access
    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en |-> (!illegal && !claim));

endmodule

// File: tb/csr_access_unit_tb_top.sv
module csr_access_unit_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] A_SCR = 12'h340;
    localparam logic [11:0] A_CNT = 12'hC00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        access_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  wsrc_sel = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] alu_val = '0;
    logic [4:0]  uimm = '0;
    logic [31:0] rd_value;
    logic        claim;
    logic        illegal;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csr_access_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .access_en (access_en),
        .wr_en     (wr_en),
        .csr_addr  (csr_addr),
        .wsrc_sel  (wsrc_sel),
        .rs1_val   (rs1_val),
        .alu_val   (alu_val),
        .uimm      (uimm),
        .rd_value  (rd_value),
        .claim     (claim),
        .illegal   (illegal)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] rs1;
        logic [31:0] alu;
        logic [4:0]  imm;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{2'd0, 32'hDEADBEEF, 32'h00001111, 5'd3,  32'hDEADBEEF},
        '{2'd1, 32'h00000005, 32'hA5A50F0F, 5'd7,  32'hA5A50F0F},
        '{2'd2, 32'hFFFFFFFF, 32'h12345678, 5'd31, 32'h0000001F},
        '{2'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd31, 32'h00000000},
        '{2'd0, 32'h12345678, 32'h0,        5'd0,  32'h12345678},
        '{2'd2, 32'h0,        32'hFFFFFFFF, 5'd5,  32'h00000005}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [1:0] s,
                            input logic [31:0] r, input logic [31:0] al,
                            input logic [4:0] im, input logic acc);
        @(negedge clk);
        access_en = acc; wr_en = 1'b1; csr_addr = a;
        wsrc_sel = s; rs1_val = r; alu_val = al; uimm = im;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(input logic [11:0] a);
        access_en = 1'b1; wr_en = 1'b0; csr_addr = a;
        #1;
    endtask

    initial begin
        logic [31:0] v0;
        // reset state
        repeat (3) @(negedge clk);
        read_at(A_CNT);
        check("R10", "counter in reset", rd_value, 32'h0);
        read_at(A_SCR);
        check("R12", "scratch in reset", rd_value, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(A_CNT);
        check("R10", "counter one edge after reset", rd_value, 32'h1);
        read_at(A_SCR);
        check("R12", "scratch after reset", rd_value, 32'h0);
        check("R3", "claim on scratch", {31'b0, claim}, 32'h1);

        // write-source table, R5 R6 R7 R8 R9
        foreach (VECS[i]) begin
            do_write(A_SCR, VECS[i].sel, VECS[i].rs1, VECS[i].alu, VECS[i].imm, 1'b1);
            read_at(A_SCR);
            case (VECS[i].sel)
                2'd0: check("R5", "rs1 source", rd_value, VECS[i].exp);
                2'd1: check("R6", "alu source", rd_value, VECS[i].exp);
                2'd2: check("R7", "uimm source", rd_value, VECS[i].exp);
                default: check("R8", "zero source", rd_value, VECS[i].exp);
            endcase
        end

        // R9: write with access disabled is ignored
        do_write(A_SCR, 2'd0, 32'hCAFEF00D, 32'h0, 5'd0, 1'b0);
        read_at(A_SCR);
        check("R9", "write without access", rd_value, 32'h00000005);

        // R1 R2 R4: unmapped neighbour address
        read_at(12'h341);
        check("R2", "unmapped read value", rd_value, 32'h0);
        check("R3", "unmapped claim", {31'b0, claim}, 32'h0);
        check("R4", "unmapped illegal", {31'b0, illegal}, 32'h1);
        read_at(12'h740);
        check("R1", "high-bit alias claim", {31'b0, claim}, 32'h0);
        do_write(12'h341, 2'd0, 32'h0BADF00D, 32'h0, 5'd0, 1'b1);
        read_at(A_SCR);
        check("R9", "write to unmapped address", rd_value, 32'h00000005);
        check("R4", "legal read not illegal", {31'b0, illegal}, 32'h0);

        // R4: idle has no trap
        @(negedge clk);
        access_en = 1'b0; csr_addr = 12'h341; #1;
        check("R4", "idle illegal", {31'b0, illegal}, 32'h0);
        check("R2", "idle read value", rd_value, 32'h0);

        // R10: counter step over five edges
        @(negedge clk);
        read_at(A_CNT);
        v0 = rd_value;
        repeat (5) @(negedge clk);
        #1;
        check("R10", "counter advance over 5 edges", rd_value, v0 + 32'd5);

        // R11: write to the read-only counter
        @(negedge clk);
        access_en = 1'b1; wr_en = 1'b1; csr_addr = A_CNT;
        wsrc_sel = 2'd0; rs1_val = 32'h0000ABCD; #1;
        v0 = rd_value;
        check("R11", "counter write claim", {31'b0, claim}, 32'h1);
        check("R11", "counter write illegal", {31'b0, illegal}, 32'h1);
        @(negedge clk);
        wr_en = 1'b0; #1;
        check("R11", "counter ignores write", rd_value, v0 + 32'd1);
        check("R11", "counter read legal", {31'b0, illegal}, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule